// File: doc/BRIEF.md
# Shaped On/Off Keying Amplitude Ramp

This block scales a stream of signed samples by a 12-bit amplitude code, so that a burst can fade in and fade out instead of starting and stopping with a hard edge. The scaled sample leaves the block through one output register, so the output always appears one clock after its input, in every mode.

The amplitude code comes from one of three sources. With keying switched off, the scaling is bypassed and each sample passes through at full scale. With keying on and the ramp source selected, an 8-bit prescaler divides the system clock. Each prescaler tick moves a 12-bit amplitude counter one step up or one step down, as the keying direction input sets. The counter stops at its end values. With keying on and the manual source selected, a 12-bit shape value supplied from outside sets the amplitude directly. Software can then draw any envelope it likes.

Top module: `shaped_key_ramp`

## Requirements
- R1: While `key_en_i` is low, `sample_o` equals the `sample_i` value presented one clock earlier, with no scaling applied.
- R2: `sample_o` is registered. A synchronous reset clears it to 0, and in every mode it reflects the inputs sampled at the previous rising edge.
- R3: With `key_en_i` high and `ramp_sel_i` low, `sample_o` equals floor(`sample_i` × `shape_val_i` / 4096), in two's-complement arithmetic with `shape_val_i` taken as unsigned.
- R4: With `key_en_i` high and `ramp_sel_i` high, the scale is the internal amplitude counter, using the same floor formula. A counter value of 0 gives an output of 0.
- R5: While the ramp source is active, the prescaler counts down once per clock from `ramp_rate_i`. It ticks on the clock where it holds 0 and then reloads, so there is one amplitude step every `ramp_rate_i`+1 clocks. A rate of 0 steps the counter on every clock.
- R6: Each prescaler tick adds one to the amplitude counter when `key_up_i` is high, and subtracts one when it is low. Between ticks the counter holds its value.
- R7: The amplitude counter saturates at 4095 when ramping up and at 0 when ramping down. It never wraps.
- R8: While the ramp source is not active (keying off, or manual source selected), the amplitude counter keeps its value and the prescaler stays loaded with `ramp_rate_i`. When the ramp source is selected again, the ramp resumes from the held amplitude.
- R9: Reset sets the amplitude counter to 0 and loads the prescaler from `ramp_rate_i`. After release with the ramp active, the first step therefore comes `ramp_rate_i`+1 clocks later.
- R10: A scale of 4095 multiplies by 4095/4096. For example, 2047 becomes 2046 and -2048 stays -2048.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| key_en_i | input | 1 | Keying enable; low bypasses the scaling |
| ramp_sel_i | input | 1 | Amplitude source: 1 = internal ramp, 0 = manual shape value |
| ramp_rate_i | input | 8 | Prescaler reload value |
| shape_val_i | input | 12 | Manual amplitude code (unsigned) |
| key_up_i | input | 1 | Ramp direction: 1 = up, 0 = down |
| sample_i | input | 12 | Signed input sample |
| sample_o | output | 12 | Signed scaled sample, one clock latency |

## Verification
The bench runs random samples through bypass and manual modes, with random shape codes and the directed codes 0 and 4095. These separate the floor rounding from truncation toward zero, and separate the /4096 scaling from a /4095 scaling. A constant full-scale positive sample is then held while the ramp climbs to its ceiling and a negative one while it falls to zero. Each output step reveals the prescaler period and the counter value, so a wrong reload count, a missed saturation or a wrapping counter all show. Interleaved stretches of manual and bypass mode, followed by a return to the ramp, show whether the amplitude is held. A final phase mixes random modes, directions, rates and samples.

// File: rtl/osk_pkg.sv
package osk_pkg;

    parameter int unsigned DATA_W  = 12;
    parameter int unsigned SCALE_W = 12;
    parameter int unsigned RATE_W  = 8;

    typedef enum logic [1:0] {
        SRC_BYPASS = 2'd0,
        SRC_MANUAL = 2'd1,
        SRC_RAMP   = 2'd2
    } amp_src_e;

    // Signed sample times unsigned scale, divided by 2**SCALE_W, floor rounding
    function automatic logic signed [DATA_W-1:0] scale_sample(
        input logic signed [DATA_W-1:0] smp,
        input logic [SCALE_W-1:0]       scl
    );
        logic signed [DATA_W+SCALE_W:0] prod;
        logic signed [DATA_W+SCALE_W:0] shifted;
        prod    = $signed(smp) * $signed({1'b0, scl});
        shifted = prod >>> SCALE_W;
        return shifted[DATA_W-1:0];
    endfunction

endpackage

// File: rtl/osk_prescaler.sv
module osk_prescaler #(
    parameter int unsigned RATE_W = osk_pkg::RATE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run_i,
    input  logic [RATE_W-1:0] rate_i,
    output logic              tick_o
);

    typedef struct packed {
        logic [RATE_W-1:0] cnt;
    } presc_t;

    presc_t st_d, st_q;
    logic   at_zero;

    assign at_zero = (st_q.cnt == '0);

    always_comb begin
        st_d   = st_q;
        tick_o = run_i && at_zero;
        if (!run_i) begin
            st_d.cnt = rate_i;
        end else if (at_zero) begin
            st_d.cnt = rate_i;
        end else begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.cnt <= rate_i;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/osk_amp_counter.sv
module osk_amp_counter #(
    parameter int unsigned SCALE_W = osk_pkg::SCALE_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               step_i,
    input  logic               up_i,
    output logic [SCALE_W-1:0] amp_o
);

    localparam logic [SCALE_W-1:0] AMP_MAX = {SCALE_W{1'b1}};
    localparam logic [SCALE_W-1:0] AMP_MIN = '0;

    typedef struct packed {
        logic [SCALE_W-1:0] amp;
    } amp_t;

    amp_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (step_i) begin
            if (up_i) begin
                if (st_q.amp != AMP_MAX) begin
                    st_d.amp = st_q.amp + 1'b1;
                end
            end else begin
                if (st_q.amp != AMP_MIN) begin
                    st_d.amp = st_q.amp - 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.amp <= AMP_MIN;
        end else begin
            st_q <= st_d;
        end
    end

    assign amp_o = st_q.amp;

endmodule

// File: rtl/osk_scaler.sv
module osk_scaler
    import osk_pkg::*;
#(
    parameter int unsigned DATA_W  = osk_pkg::DATA_W,
    parameter int unsigned SCALE_W = osk_pkg::SCALE_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  amp_src_e                 src_i,
    input  logic [SCALE_W-1:0]       manual_i,
    input  logic [SCALE_W-1:0]       amp_i,
    input  logic signed [DATA_W-1:0] sample_i,
    output logic signed [DATA_W-1:0] sample_o
);

    typedef struct packed {
        logic signed [DATA_W-1:0] smp;
    } out_t;

    out_t               st_d, st_q;
    logic [SCALE_W-1:0] scale_sel;

    always_comb begin
        unique case (src_i)
            SRC_MANUAL: scale_sel = manual_i;
            SRC_RAMP:   scale_sel = amp_i;
            default:    scale_sel = '0;
        endcase
    end

    always_comb begin
        st_d = st_q;
        if (src_i == SRC_BYPASS) begin
            st_d.smp = sample_i;
        end else begin
            st_d.smp = scale_sample(sample_i, scale_sel);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.smp <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sample_o = st_q.smp;

endmodule

// File: rtl/shaped_key_ramp.sv
module shaped_key_ramp
    import osk_pkg::*;
#(
    parameter int unsigned DATA_W  = osk_pkg::DATA_W,
    parameter int unsigned SCALE_W = osk_pkg::SCALE_W,
    parameter int unsigned RATE_W  = osk_pkg::RATE_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     key_en_i,
    input  logic                     ramp_sel_i,
    input  logic [RATE_W-1:0]        ramp_rate_i,
    input  logic [SCALE_W-1:0]       shape_val_i,
    input  logic                     key_up_i,
    input  logic signed [DATA_W-1:0] sample_i,
    output logic signed [DATA_W-1:0] sample_o
);

    amp_src_e           src_w;
    logic               ramp_run_w;
    logic               tick_w;
    logic [SCALE_W-1:0] amp_w;

    always_comb begin
        if (!key_en_i) begin
            src_w = SRC_BYPASS;
        end else if (ramp_sel_i) begin
            src_w = SRC_RAMP;
        end else begin
            src_w = SRC_MANUAL;
        end
    end

    assign ramp_run_w = (src_w == SRC_RAMP);

    osk_prescaler #(
        .RATE_W (RATE_W)
    ) u_presc (
        .clk    (clk),
        .rst    (rst),
        .run_i  (ramp_run_w),
        .rate_i (ramp_rate_i),
        .tick_o (tick_w)
    );

    osk_amp_counter #(
        .SCALE_W (SCALE_W)
    ) u_amp (
        .clk    (clk),
        .rst    (rst),
        .step_i (tick_w),
        .up_i   (key_up_i),
        .amp_o  (amp_w)
    );

    osk_scaler #(
        .DATA_W  (DATA_W),
        .SCALE_W (SCALE_W)
    ) u_scale (
        .clk      (clk),
        .rst      (rst),
        .src_i    (src_w),
        .manual_i (shape_val_i),
        .amp_i    (amp_w),
        .sample_i (sample_i),
        .sample_o (sample_o)
    );

endmodule

// File: rtl/osk_checker.sv
module osk_checker #(
    parameter int unsigned DATA_W  = osk_pkg::DATA_W,
    parameter int unsigned SCALE_W = osk_pkg::SCALE_W,
    parameter int unsigned RATE_W  = osk_pkg::RATE_W
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     key_en_i,
    input logic                     ramp_sel_i,
    input logic [RATE_W-1:0]        ramp_rate_i,
    input logic                     key_up_i,
    input logic signed [DATA_W-1:0] sample_i,
    input logic signed [DATA_W-1:0] sample_o,
    input logic                     tick_w,
    input logic [SCALE_W-1:0]       amp_w
);

    localparam logic [SCALE_W-1:0] AMP_TOP = {SCALE_W{1'b1}};

    // R1
    bypass_pass_chk: assert property (@(posedge clk) disable iff (rst)
        !key_en_i |=> sample_o == $past(sample_i));

    // R4
    zero_amp_chk: assert property (@(posedge clk) disable iff (rst)
        (key_en_i && ramp_sel_i && amp_w == '0) |=> sample_o == '0);

    // R5
    tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        (tick_w && key_en_i && ramp_sel_i && ramp_rate_i != '0) |=> !tick_w);

    // R6
    hold_between_chk: assert property (@(posedge clk) disable iff (rst)
        !tick_w |=> $stable(amp_w));

    // R6
    step_up_chk: assert property (@(posedge clk) disable iff (rst)
        (tick_w && key_up_i && amp_w != AMP_TOP) |=> amp_w == $past(amp_w) + 1'b1);

    // R7
    ceil_sat_chk: assert property (@(posedge clk) disable iff (rst)
        (tick_w && key_up_i && amp_w == AMP_TOP) |=> amp_w == AMP_TOP);

    // R7
    floor_sat_chk: assert property (@(posedge clk) disable iff (rst)
        (tick_w && !key_up_i && amp_w == '0) |=> amp_w == '0);

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(key_en_i && ramp_sel_i) |=> $stable(amp_w));

endmodule

bind shaped_key_ramp osk_checker #(
    .DATA_W  (DATA_W),
    .SCALE_W (SCALE_W),
    .RATE_W  (RATE_W)
) u_osk_chk (
    .clk         (clk),
    .rst         (rst),
    .key_en_i    (key_en_i),
    .ramp_sel_i  (ramp_sel_i),
    .ramp_rate_i (ramp_rate_i),
    .key_up_i    (key_up_i),
    .sample_i    (sample_i),
    .sample_o    (sample_o),
    .tick_w      (tick_w),
    .amp_w       (amp_w)
);

// File: tb/tb_shaped_key_ramp.sv
module tb_shaped_key_ramp;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              key_en_i = 1'b1;
    logic              ramp_sel_i = 1'b1;
    logic [7:0]        ramp_rate_i = 8'd3;
    logic [11:0]       shape_val_i = '0;
    logic              key_up_i = 1'b1;
    logic signed [11:0] sample_i = '0;
    logic signed [11:0] sample_o;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    // bench model of the requirements
    int m_amp   = 0;
    int m_presc = 3;
    int m_exp   = 0;

    shaped_key_ramp dut (
        .clk         (clk),
        .rst         (rst),
        .key_en_i    (key_en_i),
        .ramp_sel_i  (ramp_sel_i),
        .ramp_rate_i (ramp_rate_i),
        .shape_val_i (shape_val_i),
        .key_up_i    (key_up_i),
        .sample_i    (sample_i),
        .sample_o    (sample_o)
    );

    always #10 clk = ~clk;

    function automatic int floor_scale(input int smp, input int scl);
        int p;
        p = smp * scl;
        return p >>> 12;
    endfunction

    function automatic int expect_out(input bit en, input bit sel, input int smp,
                                      input int man, input int amp);
        if (!en) return smp;
        if (sel) return floor_scale(smp, amp);
        return floor_scale(smp, man);
    endfunction

    task automatic chk(input string req, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_errors++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    // one clock: inputs already driven; update model at edge; check at negedge
    task automatic cycle(input string req);
        @(posedge clk);
        if (rst) begin
            m_exp   = 0;
            m_amp   = 0;
            m_presc = int'(ramp_rate_i);
        end else begin
            m_exp = expect_out(key_en_i, ramp_sel_i, int'(sample_i),
                               int'(shape_val_i), m_amp);
            if (key_en_i && ramp_sel_i) begin
                if (m_presc == 0) begin
                    m_presc = int'(ramp_rate_i);
                    if (key_up_i && m_amp < 4095) m_amp = m_amp + 1;
                    else if (!key_up_i && m_amp > 0) m_amp = m_amp - 1;
                end else begin
                    m_presc = m_presc - 1;
                end
            end else begin
                m_presc = int'(ramp_rate_i);
            end
        end
        @(negedge clk);
        chk(req, int'(sample_o), m_exp);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        sample_i = 12'sd1000;
        // R9 R2: reset state
        for (int i = 0; i < 3; i++) cycle("R9 reset output");
        @(negedge clk);
        rst = 1'b0;
        // R9: first steps come rate+1 clocks after release
        for (int i = 0; i < 12; i++) cycle("R9 first step timing");

        // R1: bypass with random samples
        key_en_i = 1'b0;
        for (int i = 0; i < 200; i++) begin
            sample_i = 12'($urandom);
            cycle("R1 bypass");
        end
        sample_i = -12'sd2048; cycle("R1 bypass min");
        sample_i = 12'sd2047;  cycle("R1 bypass max");

        // R3: manual scaling
        key_en_i = 1'b1; ramp_sel_i = 1'b0;
        for (int i = 0; i < 300; i++) begin
            sample_i = 12'($urandom);
            shape_val_i = 12'($urandom);
            cycle("R3 manual");
        end
        shape_val_i = 12'd0; sample_i = -12'sd2048; cycle("R3 manual zero");
        shape_val_i = 12'hFFF;
        sample_i = 12'sd2047;  cycle("R10 ones positive");
        sample_i = -12'sd2048; cycle("R10 ones negative");
        sample_i = -12'sd1;    cycle("R10 floor of -1");
        shape_val_i = 12'd1; sample_i = -12'sd5; cycle("R3 floor negative");

        // R5 R6 R7: ramp up to saturation, rate 2
        ramp_sel_i = 1'b1; ramp_rate_i = 8'd2; key_up_i = 1'b1;
        sample_i = 12'sd2047;
        for (int i = 0; i < 12400; i++) cycle("R6 ramp up");
        for (int i = 0; i < 40; i++) cycle("R7 ceiling hold");
        sample_i = -12'sd2048; cycle("R10 ramp at ceiling");

        // R8: leave ramp mode partway down, then resume
        key_up_i = 1'b0; sample_i = 12'sd2047;
        for (int i = 0; i < 301; i++) cycle("R6 ramp down");
        ramp_sel_i = 1'b0;
        for (int i = 0; i < 60; i++) begin
            shape_val_i = 12'($urandom);
            sample_i = 12'($urandom);
            cycle("R8 manual interlude");
        end
        key_en_i = 1'b0;
        for (int i = 0; i < 30; i++) cycle("R8 bypass interlude");
        key_en_i = 1'b1; ramp_sel_i = 1'b1; sample_i = 12'sd2047;
        for (int i = 0; i < 40; i++) cycle("R8 resume");

        // R7 R4: rate 0, fall to zero with negative sample
        ramp_rate_i = 8'd0; sample_i = -12'sd2048;
        for (int i = 0; i < 4200; i++) cycle("R7 floor");
        for (int i = 0; i < 20; i++) cycle("R4 zero amplitude");

        // R5: rate changes mid-count
        key_up_i = 1'b1;
        for (int k = 0; k < 20; k++) begin
            ramp_rate_i = 8'($urandom_range(0, 9));
            for (int i = 0; i < 25; i++) cycle("R5 rate change");
        end

        // R2: mixed random operation
        for (int k = 0; k < 150; k++) begin
            key_en_i = ($urandom_range(0, 4) != 0);
            ramp_sel_i = ($urandom_range(0, 2) != 0);
            key_up_i = $urandom_range(0, 1) != 0;
            ramp_rate_i = 8'($urandom_range(0, 6));
            for (int i = 0; i < 20; i++) begin
                sample_i = 12'($urandom);
                shape_val_i = 12'($urandom);
                cycle("R2 mixed");
            end
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule